// File: doc/BRIEF.md
# Bidirectional Universal Bus Register

This block sits between two 18-bit buses, called side A and side B, and moves data between them in both directions. Each direction has its own storage cell and three controls: an open control, a strobe and a drive control. While the open control is high the cell passes data straight through, one system clock later. While it is low the cell holds its value, except that a high-to-low transition of the strobe loads the data currently on the source bus. Each direction can therefore be transparent, holding, or capturing on a strobe edge.

The block runs entirely in one system clock domain. Each strobe is treated as an asynchronous level. It passes through a synchronizer of configurable depth, and its falling edge is found by comparing two successive synchronized samples. Each side gets a data output and an active-high drive indication, which an outside tri-state buffer uses. Side B is driven when the A-to-B drive control is high. Side A is driven when the B-to-A drive control is low; that control is inverted inside the block. A disabled side shows all zeros on its data output. The value stored behind it is kept.

Top module: `dual_bus_register`

## Requirements
- R1: Each direction carries 18 data bits with no reordering: `b_data_o` is sourced only from `a_in` and `a_data_o` only from `b_in`, and bit k of the output equals bit k of the stored word.
- R2: When a direction's open control is high at a rising system-clock edge, that cell stores the source bus value sampled at that edge. The enabled output shows it after that same edge.
- R3: When the open control is low and no falling strobe edge has been detected, the stored value does not change, whatever the source bus does.
- R4: With the open control low, a strobe that falls between two system edges is first seen at the next edge. The cell then loads the source bus value present at the third edge counted from that one, and the output changes after that third edge and not before.
- R5: A rising strobe, or a strobe held steady at either level, never loads data. This includes closing the open control while the strobe is high and then keeping the strobe high.
- R6: `b_drive_o` equals the value of `a2b_drive` (active high) sampled at the previous rising edge.
- R7: `a_drive_o` equals the inverse of `b2a_drive_n` (active low) sampled at the previous rising edge.
- R8: While a side's drive indication is low, its data output is all zeros. The stored value is kept and reappears when the drive indication returns high.
- R9: A synchronous active-high `rst` clears both stored words and both drive indications and empties the strobe synchronizers. A strobe that sits low when reset is released does not count as a falling edge.
- R10: The two directions are independent: controls and data of one direction have no effect on the other direction's stored value or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Data arriving from side A |
| b_in | input | 18 | Data arriving from side B |
| a2b_open | input | 1 | A-to-B transparency control, active high |
| a2b_strobe | input | 1 | A-to-B capture strobe, falling edge loads, asynchronous |
| a2b_drive | input | 1 | A-to-B drive control, active high |
| b2a_open | input | 1 | B-to-A transparency control, active high |
| b2a_strobe | input | 1 | B-to-A capture strobe, falling edge loads, asynchronous |
| b2a_drive_n | input | 1 | B-to-A drive control, active low |
| b_data_o | output | 18 | Data toward side B, zero when not driven |
| b_drive_o | output | 1 | Tri-state enable for side B, active high |
| a_data_o | output | 18 | Data toward side A, zero when not driven |
| a_drive_o | output | 1 | Tri-state enable for side A, active high |

## Verification
The directed part walks one direction through flow, hold, a rising strobe, a falling strobe and a latch closed while the strobe is high. It checks the output just before and just after the third edge of the capture window, which separates a correctly timed capture from one that comes a cycle early or late. It also catches a capture on the wrong strobe edge. Drive checks with the stored value held behind them separate output gating from loss of state. Checks with the two drive polarities driven against each other expose a swapped or missing inversion. The random part toggles all controls, strobes, data and an occasional reset for both directions at once, and compares against a cycle model in the bench. Any coupling between directions, or a wrong priority between flow and capture, shows up there.

// File: rtl/bus_reg_pkg.sv
package bus_reg_pkg;

  typedef enum logic [1:0] {
    CELL_HOLD    = 2'd0,
    CELL_FLOW    = 2'd1,
    CELL_CAPTURE = 2'd2
  } cell_mode_e;

  // A falling edge: older sample high, newer sample low.
  function automatic logic edge_is_fall(input logic older, input logic newer);
    return older & ~newer;
  endfunction

  // Transparency wins over a strobe edge in the same cycle.
  function automatic cell_mode_e pick_mode(input logic open, input logic fall);
    if (open)      return CELL_FLOW;
    else if (fall) return CELL_CAPTURE;
    else           return CELL_HOLD;
  endfunction

  // Normalise a drive control of either polarity to active high.
  function automatic logic drive_active(input logic ctl, input logic active_low);
    return active_low ? ~ctl : ctl;
  endfunction

endpackage

// File: rtl/bus_strobe_sync.sv
module bus_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  output logic fall_o
);
  import bus_reg_pkg::*;

  localparam int LAST = STAGES - 1;

  logic [LAST:0] sr;
  logic          older;

  always_ff @(posedge clk) begin
    if (rst) sr[0] <= 1'b0;
    else     sr[0] <= strobe_i;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) sr[g] <= 1'b0;
        else     sr[g] <= sr[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) older <= 1'b0;
    else     older <= sr[LAST];
  end

  assign fall_o = edge_is_fall(older, sr[LAST]);

endmodule

// File: rtl/bus_store_cell.sv
module bus_store_cell #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         open_i,
  input  logic         fall_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] q_o
);
  import bus_reg_pkg::*;

  cell_mode_e mode;

  always_comb mode = pick_mode(open_i, fall_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= '0;
    end else begin
      case (mode)
        CELL_FLOW, CELL_CAPTURE: q_o <= din_i;
        default:                 q_o <= q_o;
      endcase
    end
  end

endmodule

// File: rtl/bus_dir_path.sv
module bus_dir_path #(
  parameter int W           = 18,
  parameter int SYNC_STAGES = 2,
  parameter bit DRIVE_LOW   = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src_i,
  input  logic         open_i,
  input  logic         strobe_i,
  input  logic         drive_ctl_i,
  output logic [W-1:0] data_o,
  output logic         drive_o,
  output logic [W-1:0] store_o,
  output logic         fall_o
);
  import bus_reg_pkg::*;

  logic en_q;

  bus_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (strobe_i),
    .fall_o   (fall_o)
  );

  bus_store_cell #(.W(W)) u_cell (
    .clk    (clk),
    .rst    (rst),
    .open_i (open_i),
    .fall_i (fall_o),
    .din_i  (src_i),
    .q_o    (store_o)
  );

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= drive_active(drive_ctl_i, DRIVE_LOW);
  end

  assign drive_o = en_q;
  assign data_o  = en_q ? store_o : '0;

endmodule

// File: rtl/dual_bus_register.sv
module dual_bus_register #(
  parameter int W           = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         a2b_open,
  input  logic         a2b_strobe,
  input  logic         a2b_drive,
  input  logic         b2a_open,
  input  logic         b2a_strobe,
  input  logic         b2a_drive_n,
  output logic [W-1:0] b_data_o,
  output logic         b_drive_o,
  output logic [W-1:0] a_data_o,
  output logic         a_drive_o
);

  // Named internal events, brought out for the checker.
  logic [W-1:0] ab_store;
  logic [W-1:0] ba_store;
  logic         ab_fall;
  logic         ba_fall;

  bus_dir_path #(.W(W), .SYNC_STAGES(SYNC_STAGES), .DRIVE_LOW(1'b0)) u_a2b (
    .clk         (clk),
    .rst         (rst),
    .src_i       (a_in),
    .open_i      (a2b_open),
    .strobe_i    (a2b_strobe),
    .drive_ctl_i (a2b_drive),
    .data_o      (b_data_o),
    .drive_o     (b_drive_o),
    .store_o     (ab_store),
    .fall_o      (ab_fall)
  );

  bus_dir_path #(.W(W), .SYNC_STAGES(SYNC_STAGES), .DRIVE_LOW(1'b1)) u_b2a (
    .clk         (clk),
    .rst         (rst),
    .src_i       (b_in),
    .open_i      (b2a_open),
    .strobe_i    (b2a_strobe),
    .drive_ctl_i (b2a_drive_n),
    .data_o      (a_data_o),
    .drive_o     (a_drive_o),
    .store_o     (ba_store),
    .fall_o      (ba_fall)
  );

endmodule

// File: rtl/dual_bus_register_chk.sv
module dual_bus_register_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         a2b_open,
  input logic         b2a_open,
  input logic         a2b_drive,
  input logic         b2a_drive_n,
  input logic [W-1:0] b_data_o,
  input logic         b_drive_o,
  input logic [W-1:0] a_data_o,
  input logic         a_drive_o,
  input logic [W-1:0] ab_store,
  input logic [W-1:0] ba_store,
  input logic         ab_fall,
  input logic         ba_fall
);

  // R2
  a2b_flow_chk: assert property (@(posedge clk) disable iff (rst)
    a2b_open |=> ab_store == $past(a_in));
  // R2
  b2a_flow_chk: assert property (@(posedge clk) disable iff (rst)
    b2a_open |=> ba_store == $past(b_in));
  // R3
  a2b_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!a2b_open && !ab_fall) |=> $stable(ab_store));
  // R3
  b2a_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!b2a_open && !ba_fall) |=> $stable(ba_store));
  // R4
  a2b_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!a2b_open && ab_fall) |=> ab_store == $past(a_in));
  // R4
  b2a_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!b2a_open && ba_fall) |=> ba_store == $past(b_in));
  // R5
  fall_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (ab_fall |=> !ab_fall) and (ba_fall |=> !ba_fall));
  // R6
  b_drive_chk: assert property (@(posedge clk) disable iff (rst)
    b_drive_o == $past(a2b_drive) || $past(rst));
  // R7
  a_drive_chk: assert property (@(posedge clk) disable iff (rst)
    b2a_drive_n |=> !a_drive_o);
  // R7
  a_drive_on_chk: assert property (@(posedge clk) disable iff (rst)
    !b2a_drive_n |=> a_drive_o);
  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!b_drive_o |-> b_data_o == '0) and (!a_drive_o |-> a_data_o == '0));
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (ab_store == '0 && ba_store == '0 && !a_drive_o && !b_drive_o));

endmodule

bind dual_bus_register dual_bus_register_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .a_in        (a_in),
  .b_in        (b_in),
  .a2b_open    (a2b_open),
  .b2a_open    (b2a_open),
  .a2b_drive   (a2b_drive),
  .b2a_drive_n (b2a_drive_n),
  .b_data_o    (b_data_o),
  .b_drive_o   (b_drive_o),
  .a_data_o    (a_data_o),
  .a_drive_o   (a_drive_o),
  .ab_store    (ab_store),
  .ba_store    (ba_store),
  .ab_fall     (ab_fall),
  .ba_fall     (ba_fall)
);

// File: tb/tb_dual_bus_register.sv
`timescale 1ns/1ps
module tb_dual_bus_register;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         a2b_open = 0, a2b_strobe = 0, a2b_drive = 0;
  logic         b2a_open = 0, b2a_strobe = 0, b2a_drive_n = 1;
  logic [W-1:0] b_data_o, a_data_o;
  logic         b_drive_o, a_drive_o;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dual_bus_register dut (.*);

  // Bench cycle model: strobe history h1 (last edge), h2, h3 (oldest).
  logic [W-1:0] m_ab, m_ba;
  logic m_ben, m_aen;
  logic [2:0] hab = '0, hba = '0;

  function automatic logic [W-1:0] expect_out(input logic en, input logic [W-1:0] v);
    return en ? v : '0;
  endfunction

  function automatic logic [W-1:0] next_word(input logic open, input logic [2:0] h,
                                             input logic [W-1:0] din, input logic [W-1:0] cur);
    // strobe seen high three edges ago and low two edges ago -> load now
    if (open || (h[2] && !h[1])) return din;
    return cur;
  endfunction

  task automatic model_edge();
    if (rst) begin
      m_ab = '0; m_ba = '0; m_ben = 0; m_aen = 0; hab = '0; hba = '0;
    end else begin
      m_ab = next_word(a2b_open, hab, a_in, m_ab);
      m_ba = next_word(b2a_open, hba, b_in, m_ba);
      m_ben = a2b_drive;
      m_aen = ~b2a_drive_n;
      hab = {hab[1:0], a2b_strobe};
      hba = {hba[1:0], b2a_strobe};
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(4.0 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    tick(3);
    rst = 0;
    // R9 reset state
    check("R9 b_data", b_data_o, '0);
    check("R9 a_data", a_data_o, '0);
    check("R9 drives", {16'd0, a_drive_o, b_drive_o}, '0);
    tick(4);
    check("R9 strobe low after reset no capture", {17'd0, b_drive_o}, '0);

    // R2 / R6 / R1 transparent flow
    a2b_drive = 1; a2b_open = 1; a_in = 18'h2_0001; tick();
    check("R6 b_drive", {17'd0, b_drive_o}, 18'd1);
    check("R1 R2 flow", b_data_o, 18'h2_0001);
    a_in = 18'h1_5A5A; tick();
    check("R2 flow follows", b_data_o, 18'h1_5A5A);

    // R3 hold
    a2b_open = 0; a_in = 18'h0_3C3C; tick(2);
    check("R3 hold", b_data_o, 18'h1_5A5A);

    // R5 rising strobe loads nothing
    a2b_strobe = 1; tick(4);
    check("R5 rising no load", b_data_o, 18'h1_5A5A);

    // R4 falling strobe: old after 2 edges, new after 3rd
    a2b_strobe = 0; tick(2);
    check("R4 not yet", b_data_o, 18'h1_5A5A);
    tick();
    check("R4 captured", b_data_o, 18'h0_3C3C);
    a_in = 18'h3_0F0F; tick(3);
    check("R3 hold after capture", b_data_o, 18'h0_3C3C);

    // R5 close while strobe high, strobe stays high
    a2b_strobe = 1; a2b_open = 1; tick(3);
    a2b_open = 0; a_in = 18'h2_2222; tick(4);
    check("R5 close with strobe high", b_data_o, 18'h3_0F0F);

    // R8 disabled zero, value retained
    a2b_drive = 0; tick();
    check("R8 zero when idle", b_data_o, '0);
    check("R6 drive off", {17'd0, b_drive_o}, '0);
    a_in = 18'h1_1111; tick();
    a2b_drive = 1; tick();
    check("R8 retained", b_data_o, 18'h3_0F0F);

    // R7 / R10 B-to-A active-low drive
    check("R7 drive_n high disables", {17'd0, a_drive_o}, '0);
    b2a_drive_n = 0; b2a_open = 1; b_in = 18'h3_FFFE; tick();
    check("R7 drive_n low enables", {17'd0, a_drive_o}, 18'd1);
    check("R1 b2a flow", a_data_o, 18'h3_FFFE);
    check("R10 other side untouched", b_data_o, 18'h3_0F0F);

    // Random phase: compare against bench model each cycle
    for (int i = 0; i < 4000; i++) begin
      rst         = ($urandom_range(0, 299) == 0);
      a_in        = W'($urandom);
      b_in        = W'($urandom);
      a2b_open    = ($urandom_range(0, 3) == 0);
      b2a_open    = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 2) == 0) a2b_strobe = ~a2b_strobe;
      if ($urandom_range(0, 2) == 0) b2a_strobe = ~b2a_strobe;
      if ($urandom_range(0, 7) == 0) a2b_drive = ~a2b_drive;
      if ($urandom_range(0, 7) == 0) b2a_drive_n = ~b2a_drive_n;
      tick();
      check("R2 R3 R4 R8 R10 b side", b_data_o, expect_out(m_ben, m_ab));
      check("R2 R3 R4 R8 R10 a side", a_data_o, expect_out(m_aen, m_ba));
      check("R6 R7 R9 drives", {16'd0, a_drive_o, b_drive_o}, {16'd0, m_aen, m_ben});
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule